// File: doc/BRIEF.md
# Router Event Counters and Energy Accumulator

This block sits beside a virtual-channel router. It watches six classes of per-cycle event strobes. Each strobe is a vector with one bit per router port. The six classes are: a flit written into a VC FIFO, a VC picked by arbitration after route computation, a read or write of the free-VC queue during VC allocation, a flit removed from an input buffer, a crossbar traversal, and a flit crossing a link to the next tile. For each class the block keeps a saturating event count. In the same cycle it adds the number of events times a per-class weight into one of four component energy accumulators.

The four components are:
- buffer, fed by writes and reads;
- arbiter, fed by arbitrations and free-VC queue accesses;
- crossbar;
- link.

A static term supplied from outside is added to each component on its way to the output. The overall energy is the saturating sum of the four component figures. A synchronous clear restarts every count and accumulator.

Top module: `rtr_energy_meter`

## Requirements
- R1: After reset, every count is 0 and every component energy output equals its static input. The total equals the sum of the four static inputs.
- R2: Each event counter adds the number of set bits in its strobe vector. The count is visible on the output in the cycle after the strobe. Several ports may fire in the same cycle.
- R3: An event counter saturates at 2^CNT_W-1 and never wraps.
- R4: The buffer accumulator grows by popcount(bwr)*w_bwr + popcount(brd)*w_brd each cycle. e_buf is that accumulator plus s_buf.
- R5: The arbiter accumulator grows by popcount(arb)*w_arb + popcount(vcq)*w_vcq each cycle. e_arb is that accumulator plus s_arb.
- R6: The crossbar and link accumulators grow by popcount*weight of their own class each cycle. e_xbar and e_link add s_xbar and s_link respectively.
- R7: e_total is e_buf+e_arb+e_xbar+e_link, saturating at 2^ACC_W-1.
- R8: Component accumulators and component outputs saturate at 2^ACC_W-1 and never wrap.
- R9: When clr is high, every count and accumulator reads 0 in the next cycle. Strobes in that same cycle are dropped.
- R10: Each cycle's events are weighted with the weights present in that cycle. A later change to a weight does not rescale energy already accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counts and accumulators |
| stb_bwr | input | NUM_PORTS | Buffer-write strobes |
| stb_arb | input | NUM_PORTS | VC arbitration strobes |
| stb_vcq | input | NUM_PORTS | Free-VC queue access strobes |
| stb_brd | input | NUM_PORTS | Buffer-read strobes |
| stb_xbar | input | NUM_PORTS | Crossbar traversal strobes |
| stb_link | input | NUM_PORTS | Link traversal strobes |
| w_bwr | input | WGT_W | Energy weight per buffer write |
| w_arb | input | WGT_W | Energy weight per arbitration |
| w_vcq | input | WGT_W | Energy weight per free-VC queue access |
| w_brd | input | WGT_W | Energy weight per buffer read |
| w_xbar | input | WGT_W | Energy weight per crossbar traversal |
| w_link | input | WGT_W | Energy weight per link traversal |
| s_buf | input | ACC_W | Static term for buffer component |
| s_arb | input | ACC_W | Static term for arbiter component |
| s_xbar | input | ACC_W | Static term for crossbar component |
| s_link | input | ACC_W | Static term for link component |
| cnt_bwr | output | CNT_W | Buffer-write count |
| cnt_arb | output | CNT_W | Arbitration count |
| cnt_vcq | output | CNT_W | Free-VC queue access count |
| cnt_brd | output | CNT_W | Buffer-read count |
| cnt_xbar | output | CNT_W | Crossbar traversal count |
| cnt_link | output | CNT_W | Link traversal count |
| e_buf | output | ACC_W | Buffer component energy |
| e_arb | output | ACC_W | Arbiter component energy |
| e_xbar | output | ACC_W | Crossbar component energy |
| e_link | output | ACC_W | Link component energy |
| e_total | output | ACC_W | Sum of component energies |

## Verification
The bench runs with narrow counters and accumulators so that both kinds of saturation are reached in a few cycles.

- A counter that wrapped would drop to a small value after passing its limit. A total that was truncated rather than clamped would show a small figure once the components overflowed.
- All ports strobing together tests the popcount. A design that counted only "any strobe" would add 1 instead of 4.
- A clear issued together with strobes must leave zeros. A design that let the strobes win would show leftover counts.
- A weight change in the middle of a run must not change energy already banked. A design that multiplied the final count by the current weight would report the wrong total after the change.

// File: rtl/rtr_energy_pkg.sv
package rtr_energy_pkg;
   localparam int NUM_EV   = 6;
   localparam int NUM_COMP = 4;

   typedef enum logic [2:0] {
      EV_BWR  = 3'd0,
      EV_ARB  = 3'd1,
      EV_VCQ  = 3'd2,
      EV_BRD  = 3'd3,
      EV_XBAR = 3'd4,
      EV_LINK = 3'd5
   } ev_e;

   typedef enum logic [1:0] {
      CP_BUF  = 2'd0,
      CP_ARB  = 2'd1,
      CP_XBAR = 2'd2,
      CP_LINK = 2'd3
   } comp_e;
endpackage

// File: rtl/rtr_evt_counter.sv
module rtr_evt_counter #(
   parameter int NUM_PORTS = 5,
   parameter int CNT_W     = 32,
   parameter int PC_W      = $clog2(NUM_PORTS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [NUM_PORTS-1:0] stb_i,
   output logic [PC_W-1:0]      pc_o,
   output logic [CNT_W-1:0]     cnt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   sum;

   always_comb begin
      pc_o = '0;
      for (int p = 0; p < NUM_PORTS; p++)
         pc_o = pc_o + PC_W'(stb_i[p]);
   end

   assign sum = {1'b0, cnt_q} + (CNT_W+1)'(pc_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (sum[CNT_W])
         cnt_q <= '1;
      else
         cnt_q <= sum[CNT_W-1:0];
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/rtr_energy_acc.sv
module rtr_energy_acc #(
   parameter int NUM_IN = 2,
   parameter int PC_W   = 3,
   parameter int WGT_W  = 16,
   parameter int ACC_W  = 48
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clr,
   input  logic [NUM_IN-1:0][PC_W-1:0]       pc_i,
   input  logic [NUM_IN-1:0][WGT_W-1:0]      wgt_i,
   input  logic [ACC_W-1:0]                  static_i,
   output logic [ACC_W-1:0]                  acc_o,
   output logic [ACC_W-1:0]                  e_o
);
   localparam int PROD_W = WGT_W + PC_W;
   localparam int INC_W  = PROD_W + $clog2(NUM_IN + 1);

   logic [NUM_IN-1:0][PROD_W-1:0] prod;
   logic [INC_W-1:0]              inc;
   logic [ACC_W-1:0]              acc_q;
   logic [ACC_W:0]                nxt;
   logic [ACC_W:0]                esum;

   for (genvar g = 0; g < NUM_IN; g++) begin : g_prod
      assign prod[g] = PROD_W'(pc_i[g]) * PROD_W'(wgt_i[g]);
   end

   always_comb begin
      inc = '0;
      for (int k = 0; k < NUM_IN; k++)
         inc = inc + INC_W'(prod[k]);
   end

   assign nxt = {1'b0, acc_q} + (ACC_W+1)'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clr)
         acc_q <= '0;
      else if (nxt[ACC_W])
         acc_q <= '1;
      else
         acc_q <= nxt[ACC_W-1:0];
   end

   assign esum  = {1'b0, acc_q} + {1'b0, static_i};
   assign e_o   = esum[ACC_W] ? '1 : esum[ACC_W-1:0];
   assign acc_o = acc_q;
endmodule

// File: rtl/rtr_energy_meter.sv
module rtr_energy_meter
   import rtr_energy_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int CNT_W     = 32,
   parameter int WGT_W     = 16,
   parameter int ACC_W     = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [NUM_PORTS-1:0] stb_bwr,
   input  logic [NUM_PORTS-1:0] stb_arb,
   input  logic [NUM_PORTS-1:0] stb_vcq,
   input  logic [NUM_PORTS-1:0] stb_brd,
   input  logic [NUM_PORTS-1:0] stb_xbar,
   input  logic [NUM_PORTS-1:0] stb_link,
   input  logic [WGT_W-1:0]     w_bwr,
   input  logic [WGT_W-1:0]     w_arb,
   input  logic [WGT_W-1:0]     w_vcq,
   input  logic [WGT_W-1:0]     w_brd,
   input  logic [WGT_W-1:0]     w_xbar,
   input  logic [WGT_W-1:0]     w_link,
   input  logic [ACC_W-1:0]     s_buf,
   input  logic [ACC_W-1:0]     s_arb,
   input  logic [ACC_W-1:0]     s_xbar,
   input  logic [ACC_W-1:0]     s_link,
   output logic [CNT_W-1:0]     cnt_bwr,
   output logic [CNT_W-1:0]     cnt_arb,
   output logic [CNT_W-1:0]     cnt_vcq,
   output logic [CNT_W-1:0]     cnt_brd,
   output logic [CNT_W-1:0]     cnt_xbar,
   output logic [CNT_W-1:0]     cnt_link,
   output logic [ACC_W-1:0]     e_buf,
   output logic [ACC_W-1:0]     e_arb,
   output logic [ACC_W-1:0]     e_xbar,
   output logic [ACC_W-1:0]     e_link,
   output logic [ACC_W-1:0]     e_total
);
   localparam int PC_W = $clog2(NUM_PORTS + 1);

   if (NUM_PORTS < 1) begin : g_chk_ports
      $error("rtr_energy_meter: NUM_PORTS must be at least 1");
   end
   if (CNT_W < PC_W) begin : g_chk_cnt
      $error("rtr_energy_meter: CNT_W too narrow for one cycle of events");
   end
   if (ACC_W < WGT_W + PC_W + 2) begin : g_chk_acc
      $error("rtr_energy_meter: ACC_W too narrow for one cycle increment");
   end

   logic [NUM_EV-1:0][NUM_PORTS-1:0] stb_all;
   logic [NUM_EV-1:0][PC_W-1:0]      pc_all;
   logic [NUM_EV-1:0][CNT_W-1:0]     cnt_all;
   logic [NUM_COMP-1:0][ACC_W-1:0]   acc_all;
   logic [NUM_COMP-1:0][ACC_W-1:0]   e_comp;
   logic [ACC_W+1:0]                 tsum;

   assign stb_all[EV_BWR]  = stb_bwr;
   assign stb_all[EV_ARB]  = stb_arb;
   assign stb_all[EV_VCQ]  = stb_vcq;
   assign stb_all[EV_BRD]  = stb_brd;
   assign stb_all[EV_XBAR] = stb_xbar;
   assign stb_all[EV_LINK] = stb_link;

   for (genvar e = 0; e < NUM_EV; e++) begin : g_cnt
      rtr_evt_counter #(
         .NUM_PORTS (NUM_PORTS),
         .CNT_W     (CNT_W),
         .PC_W      (PC_W)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .stb_i (stb_all[e]),
         .pc_o  (pc_all[e]),
         .cnt_o (cnt_all[e])
      );
   end

   rtr_energy_acc #(.NUM_IN(2), .PC_W(PC_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_acc_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .pc_i     ({pc_all[EV_BRD], pc_all[EV_BWR]}),
      .wgt_i    ({w_brd, w_bwr}),
      .static_i (s_buf),
      .acc_o    (acc_all[CP_BUF]),
      .e_o      (e_comp[CP_BUF])
   );

   rtr_energy_acc #(.NUM_IN(2), .PC_W(PC_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_acc_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .pc_i     ({pc_all[EV_VCQ], pc_all[EV_ARB]}),
      .wgt_i    ({w_vcq, w_arb}),
      .static_i (s_arb),
      .acc_o    (acc_all[CP_ARB]),
      .e_o      (e_comp[CP_ARB])
   );

   rtr_energy_acc #(.NUM_IN(1), .PC_W(PC_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_acc_xbar (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .pc_i     (pc_all[EV_XBAR]),
      .wgt_i    (w_xbar),
      .static_i (s_xbar),
      .acc_o    (acc_all[CP_XBAR]),
      .e_o      (e_comp[CP_XBAR])
   );

   rtr_energy_acc #(.NUM_IN(1), .PC_W(PC_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_acc_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .pc_i     (pc_all[EV_LINK]),
      .wgt_i    (w_link),
      .static_i (s_link),
      .acc_o    (acc_all[CP_LINK]),
      .e_o      (e_comp[CP_LINK])
   );

   assign tsum = {2'b00, e_comp[CP_BUF]}  + {2'b00, e_comp[CP_ARB]}
               + {2'b00, e_comp[CP_XBAR]} + {2'b00, e_comp[CP_LINK]};
   assign e_total = (|tsum[ACC_W+1:ACC_W]) ? '1 : tsum[ACC_W-1:0];

   assign cnt_bwr  = cnt_all[EV_BWR];
   assign cnt_arb  = cnt_all[EV_ARB];
   assign cnt_vcq  = cnt_all[EV_VCQ];
   assign cnt_brd  = cnt_all[EV_BRD];
   assign cnt_xbar = cnt_all[EV_XBAR];
   assign cnt_link = cnt_all[EV_LINK];
   assign e_buf    = e_comp[CP_BUF];
   assign e_arb    = e_comp[CP_ARB];
   assign e_xbar   = e_comp[CP_XBAR];
   assign e_link   = e_comp[CP_LINK];
endmodule

// File: rtl/rtr_energy_meter_chk.sv
module rtr_energy_meter_chk #(
   parameter int NUM_PORTS = 5,
   parameter int CNT_W     = 32,
   parameter int ACC_W     = 48,
   parameter int NUM_EV    = 6,
   parameter int NUM_COMP  = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           clr,
   input logic [NUM_EV-1:0][CNT_W-1:0]   cnt_all,
   input logic [NUM_COMP-1:0][ACC_W-1:0] acc_all,
   input logic [NUM_COMP-1:0][ACC_W-1:0] e_comp,
   input logic [ACC_W-1:0]               e_total
);
   for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
      p_cnt_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> cnt_all[i] >= $past(cnt_all[i]));
      p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> ({1'b0, cnt_all[i]} - {1'b0, $past(cnt_all[i])}) <= (CNT_W+1)'(NUM_PORTS));
      p_cnt_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && (&cnt_all[i])) |=> (&cnt_all[i]));
      p_cnt_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> cnt_all[i] == '0);
   end

   for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
      p_acc_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> acc_all[c] >= $past(acc_all[c]));
      p_acc_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> acc_all[c] == '0);
      p_comp_ge_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
         e_comp[c] >= acc_all[c]);
      p_total_ge_comp_r7: assert property (@(posedge clk) disable iff (!rst_n)
         e_total >= e_comp[c]);
   end
endmodule

bind rtr_energy_meter rtr_energy_meter_chk #(
   .NUM_PORTS (NUM_PORTS),
   .CNT_W     (CNT_W),
   .ACC_W     (ACC_W),
   .NUM_EV    (rtr_energy_pkg::NUM_EV),
   .NUM_COMP  (rtr_energy_pkg::NUM_COMP)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (clr),
   .cnt_all (cnt_all),
   .acc_all (acc_all),
   .e_comp  (e_comp),
   .e_total (e_total)
);

// File: tb/sim_rtr_energy_meter.sv
`timescale 1ns/1ps
module sim_rtr_energy_meter;
   localparam int NP    = 4;
   localparam int CW    = 5;
   localparam int WW    = 8;
   localparam int AW    = 14;
   localparam longint CMAX = (64'd1 << CW) - 1;
   localparam longint AMAX = (64'd1 << AW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic [NP-1:0] s_bwr = '0, s_arb = '0, s_vcq = '0, s_brd = '0, s_xb = '0, s_ln = '0;
   logic [WW-1:0] w_bwr = '0, w_arb = '0, w_vcq = '0, w_brd = '0, w_xb = '0, w_ln = '0;
   logic [AW-1:0] st_buf = '0, st_arb = '0, st_xb = '0, st_ln = '0;
   logic [CW-1:0] c_bwr, c_arb, c_vcq, c_brd, c_xb, c_ln;
   logic [AW-1:0] e_buf, e_arb, e_xb, e_ln, e_tot;

   int n_cmp = 0;
   int n_bad = 0;
   longint xc [6];
   longint xa [4];

   always #4 clk = ~clk;

   rtr_energy_meter #(.NUM_PORTS(NP), .CNT_W(CW), .WGT_W(WW), .ACC_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .stb_bwr(s_bwr), .stb_arb(s_arb), .stb_vcq(s_vcq),
      .stb_brd(s_brd), .stb_xbar(s_xb), .stb_link(s_ln),
      .w_bwr(w_bwr), .w_arb(w_arb), .w_vcq(w_vcq),
      .w_brd(w_brd), .w_xbar(w_xb), .w_link(w_ln),
      .s_buf(st_buf), .s_arb(st_arb), .s_xbar(st_xb), .s_link(st_ln),
      .cnt_bwr(c_bwr), .cnt_arb(c_arb), .cnt_vcq(c_vcq),
      .cnt_brd(c_brd), .cnt_xbar(c_xb), .cnt_link(c_ln),
      .e_buf(e_buf), .e_arb(e_arb), .e_xbar(e_xb), .e_link(e_ln), .e_total(e_tot)
   );

   function automatic longint sat(longint v, longint m);
      return (v > m) ? m : v;
   endfunction

   task automatic cmp(string tag, string nm, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      longint eb, ea, ex, el;
      eb = sat(xa[0] + st_buf, AMAX);
      ea = sat(xa[1] + st_arb, AMAX);
      ex = sat(xa[2] + st_xb, AMAX);
      el = sat(xa[3] + st_ln, AMAX);
      cmp(tag, "cnt_bwr", c_bwr, xc[0]);
      cmp(tag, "cnt_arb", c_arb, xc[1]);
      cmp(tag, "cnt_vcq", c_vcq, xc[2]);
      cmp(tag, "cnt_brd", c_brd, xc[3]);
      cmp(tag, "cnt_xbar", c_xb, xc[4]);
      cmp(tag, "cnt_link", c_ln, xc[5]);
      cmp(tag, "e_buf", e_buf, eb);
      cmp(tag, "e_arb", e_arb, ea);
      cmp(tag, "e_xbar", e_xb, ex);
      cmp(tag, "e_link", e_ln, el);
      cmp(tag, "e_total", e_tot, sat(eb + ea + ex + el, AMAX));
   endtask

   // Called at a negedge: drive, update model, advance one cycle to next negedge.
   task automatic cyc(logic c, logic [NP-1:0] b0, logic [NP-1:0] a0, logic [NP-1:0] v0,
                      logic [NP-1:0] r0, logic [NP-1:0] x0, logic [NP-1:0] l0);
      clr = c; s_bwr = b0; s_arb = a0; s_vcq = v0; s_brd = r0; s_xb = x0; s_ln = l0;
      if (c) begin
         foreach (xc[i]) xc[i] = 0;
         foreach (xa[i]) xa[i] = 0;
      end else begin
         xc[0] = sat(xc[0] + $countones(b0), CMAX);
         xc[1] = sat(xc[1] + $countones(a0), CMAX);
         xc[2] = sat(xc[2] + $countones(v0), CMAX);
         xc[3] = sat(xc[3] + $countones(r0), CMAX);
         xc[4] = sat(xc[4] + $countones(x0), CMAX);
         xc[5] = sat(xc[5] + $countones(l0), CMAX);
         xa[0] = sat(xa[0] + $countones(b0) * w_bwr + $countones(r0) * w_brd, AMAX);
         xa[1] = sat(xa[1] + $countones(a0) * w_arb + $countones(v0) * w_vcq, AMAX);
         xa[2] = sat(xa[2] + $countones(x0) * w_xb, AMAX);
         xa[3] = sat(xa[3] + $countones(l0) * w_ln, AMAX);
      end
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0; s_bwr = '0; s_arb = '0; s_vcq = '0; s_brd = '0; s_xb = '0; s_ln = '0;
   endtask

   task automatic set_w(int b, int a, int v, int r, int x, int l);
      w_bwr = WW'(b); w_arb = WW'(a); w_vcq = WW'(v);
      w_brd = WW'(r); w_xb = WW'(x); w_ln = WW'(l);
   endtask

   task automatic t_reset;   // R1
      check_all("R1");
      st_buf = 14'd10; st_arb = 14'd20; st_xb = 14'd30; st_ln = 14'd40;
      #1;
      check_all("R1_static");
   endtask

   task automatic t_single;  // R2 R4 R5 R6, one class per cycle
      set_w(3, 5, 7, 11, 13, 17);
      cyc(0, 4'b0001, 0, 0, 0, 0, 0); check_all("R2_bwr_R4");
      cyc(0, 0, 4'b0010, 0, 0, 0, 0); check_all("R5_arb");
      cyc(0, 0, 0, 4'b0100, 0, 0, 0); check_all("R5_vcq");
      cyc(0, 0, 0, 0, 4'b1000, 0, 0); check_all("R4_brd");
      cyc(0, 0, 0, 0, 0, 4'b0001, 0); check_all("R6_xbar");
      cyc(0, 0, 0, 0, 0, 0, 4'b0010); check_all("R6_link");
   endtask

   task automatic t_multi;   // R2 several ports per cycle
      cyc(0, 4'b1111, 4'b1010, 4'b0110, 4'b1011, 4'b1111, 4'b0101); check_all("R2_multi_a");
      cyc(0, 4'b0011, 4'b1111, 4'b1000, 4'b0000, 4'b1110, 4'b1111); check_all("R2_multi_b");
   endtask

   task automatic t_clear;   // R9 clear wins over strobes
      cyc(1, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111); check_all("R9_clr");
      cyc(0, 4'b0001, 0, 0, 0, 0, 0); check_all("R9_after");
   endtask

   task automatic t_weight_change; // R10
      cyc(1, 0, 0, 0, 0, 0, 0);
      set_w(10, 10, 10, 10, 10, 10);
      cyc(0, 4'b0011, 4'b0001, 4'b0001, 4'b0011, 4'b0001, 4'b0001); check_all("R10_before");
      set_w(1, 2, 3, 4, 5, 6);
      cyc(0, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001); check_all("R10_after");
      set_w(100, 100, 100, 100, 100, 100);
      cyc(0, 0, 0, 0, 0, 0, 0); check_all("R10_idle");
   endtask

   task automatic t_cnt_sat;  // R3
      cyc(1, 0, 0, 0, 0, 0, 0);
      set_w(0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 10; k++) begin
         cyc(0, 4'b1111, 4'b0111, 4'b1111, 4'b1101, 4'b1111, 4'b1011);
         check_all("R3_sat");
      end
   endtask

   task automatic t_acc_sat;  // R7 R8
      cyc(1, 0, 0, 0, 0, 0, 0);
      set_w(255, 255, 255, 255, 255, 255);
      st_buf = 14'd1000; st_arb = 14'd0; st_xb = 14'd500; st_ln = 14'd16000;
      for (int k = 0; k < 10; k++) begin
         cyc(0, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111);
         check_all("R8_R7_sat");
      end
      st_ln = 14'd0;
      #1;
      check_all("R7_total");
   endtask

   initial begin
      foreach (xc[i]) xc[i] = 0;
      foreach (xa[i]) xa[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_multi();
      t_clear();
      t_weight_change();
      t_cnt_sat();
      t_acc_sat();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule